// File: doc/BRIEF.md
# Receive Completion Record Coalescer

This block sits at the completion end of a packet-receive DMA engine. For every packet the engine finishes, it takes one set of offload metadata from a valid/ready stream: flags, buffer identifier, segmentation type, segmentation header length and segment size, checksum start and offset, and a 64-bit timestamp. It turns that set into a fixed completion record that fills exactly one 64-byte line. The metadata sits in little-endian fields at the front of the line, and every other byte is zero.

Records are held in a small staging buffer and leave as one memory write into a host completion ring. Each write carries a start address, a byte count and one 64-byte data beat per record. A batch closes in four cases: it reaches the record limit set by the maximum write payload, the ring reaches its last slot, the flush input is raised, or no new record has arrived for a programmable number of cycles. The next batch starts at the ring slot that follows. After the last slot it starts again at the ring base.

Top module: `rx_cpl_coalescer`

## Requirements
- R1: Each 64-byte record places its fields at these byte offsets, least significant byte first: flags at 0–1, buffer id at 2–3, segmentation type at 4, segmentation header length at 8–9, segment size at 10–11, checksum start at 12–13, checksum offset at 14–15, timestamp at 18–25. Byte n of the line is data bits [8n+7:8n].
- R2: Bytes 5–7, bytes 16–17 and bytes 26–63 of every record are zero.
- R3: A write carries one beat per record, in arrival order. Its byte count is 64 times the number of records. The address and byte count stay fixed across all beats, and `wr_last` is high only on the final beat. A record is never split across two writes.
- R4: The number of records in a batch is bounded by `cfg_mps`: 0 gives 2 records (128 bytes), 1 gives 4 records (256 bytes), and 2 or 3 give 8 records (512 bytes). A batch that reaches its bound is written without waiting for flush or timeout. A batch below its bound is not written unless another close condition occurs.
- R5: Raising `flush` for one cycle while records are held writes them out as a partial batch. Raising `flush` with nothing held produces no write.
- R6: If `cfg_idle_limit` L is nonzero and held records see no new arrival for L cycles, the write begins (`wr_valid` high) in the cycle after the L-th idle clock edge. If L is zero, the timeout is disabled.
- R7: The address of a write is `cfg_ring_base` + 64 × (ring slot of its first record). Slots advance by one per record. A batch that fills slot `cfg_ring_entries`−1 closes immediately, and the next batch starts at slot 0.
- R8: `in_ready` is low while a write is in progress. While `wr_ready` is low, every write output holds its value.
- R9: After reset, `wr_valid` is low, `in_ready` is high and the next write starts at ring slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mps | input | 2 | Maximum write payload select (0:128 B, 1:256 B, 2/3:512 B) |
| cfg_ring_base | input | ADDR_W | Byte address of ring slot 0, 64-byte aligned |
| cfg_ring_entries | input | PTR_W | Number of slots in the completion ring (at least 1) |
| cfg_idle_limit | input | IDLE_W | Idle cycles before a partial batch is written, 0 disables |
| flush | input | 1 | Write out any held records |
| in_valid | input | 1 | Metadata valid |
| in_ready | output | 1 | Metadata accepted when high together with in_valid |
| in_flags | input | 16 | Completion flags |
| in_buf_id | input | 16 | Buffer identifier |
| in_gso_type | input | 8 | Segmentation offload type |
| in_gso_hdr_len | input | 16 | Segmentation header length |
| in_gso_size | input | 16 | Segment size |
| in_csum_start | input | 16 | Checksum start offset |
| in_csum_off | input | 16 | Checksum field offset |
| in_tstamp | input | 64 | Receive timestamp |
| wr_ready | input | 1 | Write beat accepted |
| wr_valid | output | 1 | Write beat valid |
| wr_addr | output | ADDR_W | Start address of the write |
| wr_bytes | output | LEN_W | Byte count of the write |
| wr_data | output | 512 | One 64-byte record per beat |
| wr_last | output | 1 | Final beat of the write |

## Verification
The bench drives each payload setting up to exactly its record bound. It then confirms that one record fewer stays held while the timeout is off. A limit check that is off by one would emit early or combine too many records. The idle timeout is sampled on the cycle before and the cycle after it should fire, so a counter that starts late or compares wrongly shows up as a shifted write. A ring of five slots exposes a design that lets a batch run past the last slot, or that restarts anywhere other than the base. Held `wr_ready` stalls and a flush with nothing held check that stalled beats stay unchanged and that no empty write appears.

// File: rtl/rx_cpl_coalescer.sv
module rx_cpl_coalescer #(
  parameter int ADDR_W   = 32,
  parameter int PTR_W    = 16,
  parameter int IDLE_W   = 16,
  parameter int MAX_RECS = 8,
  localparam int LINE_W  = 512,
  localparam int LEN_W   = $clog2(MAX_RECS * 64 + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_mps,
  input  logic [ADDR_W-1:0] cfg_ring_base,
  input  logic [PTR_W-1:0]  cfg_ring_entries,
  input  logic [IDLE_W-1:0] cfg_idle_limit,
  input  logic              flush,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [15:0]       in_flags,
  input  logic [15:0]       in_buf_id,
  input  logic [7:0]        in_gso_type,
  input  logic [15:0]       in_gso_hdr_len,
  input  logic [15:0]       in_gso_size,
  input  logic [15:0]       in_csum_start,
  input  logic [15:0]       in_csum_off,
  input  logic [63:0]       in_tstamp,
  input  logic              wr_ready,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [LEN_W-1:0]  wr_bytes,
  output logic [LINE_W-1:0] wr_data,
  output logic              wr_last
);
  localparam int FIELD_W = 208;
  localparam int CNT_W   = $clog2(MAX_RECS + 1);
  localparam int IDX_W   = (MAX_RECS > 1) ? $clog2(MAX_RECS) : 1;

  logic               emitting;
  logic [CNT_W-1:0]   cnt;
  logic [CNT_W-1:0]   lim;
  logic [IDX_W-1:0]   beat;
  logic [PTR_W-1:0]   wr_ptr, batch_start;
  logic               at_end;
  logic [IDLE_W-1:0]  idle_cnt;
  logic [FIELD_W-1:0] slot [MAX_RECS];
  logic [FIELD_W-1:0] rec;
  logic               timed_out, close, accept, beat_last;

  always_comb begin
    int raw;
    raw = (cfg_mps == 2'd0) ? 2 : (cfg_mps == 2'd1) ? 4 : 8;
    if (raw > MAX_RECS) raw = MAX_RECS;
    lim = CNT_W'(raw);
  end

  assign rec = {in_tstamp, 16'h0, in_csum_off, in_csum_start, in_gso_size,
                in_gso_hdr_len, 24'h0, in_gso_type, in_buf_id, in_flags};

  assign timed_out = (cfg_idle_limit != '0) && (idle_cnt >= cfg_idle_limit);
  assign close     = !emitting && (cnt != '0) &&
                     ((cnt >= lim) || at_end || flush || timed_out);
  assign in_ready  = !emitting && !close;
  assign accept    = in_valid && in_ready;
  assign beat_last = (CNT_W'(beat) + CNT_W'(1)) == cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      emitting    <= 1'b0;
      cnt         <= '0;
      beat        <= '0;
      wr_ptr      <= '0;
      batch_start <= '0;
      at_end      <= 1'b0;
      idle_cnt    <= '0;
    end else if (emitting) begin
      if (wr_ready) begin
        if (beat_last) begin
          emitting    <= 1'b0;
          cnt         <= '0;
          beat        <= '0;
          batch_start <= wr_ptr;
          at_end      <= 1'b0;
          idle_cnt    <= '0;
        end else begin
          beat <= beat + IDX_W'(1);
        end
      end
    end else begin
      if (close) begin
        emitting <= 1'b1;
        beat     <= '0;
      end
      if (accept) begin
        cnt      <= cnt + CNT_W'(1);
        at_end   <= (wr_ptr >= cfg_ring_entries - PTR_W'(1));
        wr_ptr   <= (wr_ptr >= cfg_ring_entries - PTR_W'(1)) ? '0 : wr_ptr + PTR_W'(1);
        idle_cnt <= '0;
      end else if (cnt != '0 && !(&idle_cnt)) begin
        idle_cnt <= idle_cnt + IDLE_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (accept) slot[cnt[IDX_W-1:0]] <= rec;
  end

  assign wr_valid = emitting;
  assign wr_addr  = cfg_ring_base + (ADDR_W'(batch_start) << 6);
  assign wr_bytes = LEN_W'(cnt) << 6;
  assign wr_data  = LINE_W'(slot[beat]);
  assign wr_last  = emitting && beat_last;
endmodule

module rx_cpl_coalescer_chk #(
  parameter int ADDR_W = 32,
  parameter int PTR_W  = 16,
  parameter int LEN_W  = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        cfg_mps,
  input logic [ADDR_W-1:0] cfg_ring_base,
  input logic [PTR_W-1:0]  cfg_ring_entries,
  input logic              in_ready,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [LEN_W-1:0]  wr_bytes,
  input logic [511:0]      wr_data,
  input logic              wr_last
);
  logic [15:0] beats_seen;
  logic [15:0] mps_bytes;
  logic [ADDR_W-1:0] end_slot;

  assign mps_bytes = (cfg_mps == 2'd0) ? 16'd128 : (cfg_mps == 2'd1) ? 16'd256 : 16'd512;
  assign end_slot  = ((wr_addr - cfg_ring_base) >> 6) + ADDR_W'(wr_bytes >> 6);

  always_ff @(posedge clk) begin
    if (!rst_n) beats_seen <= '0;
    else if (wr_valid && wr_ready) beats_seen <= wr_last ? 16'd0 : beats_seen + 16'd1;
  end

  assert_len_within_mps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (16'(wr_bytes) <= mps_bytes) && (wr_bytes != '0) && (wr_bytes[5:0] == 6'd0));

  assert_beats_match_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_ready && wr_last |-> (32'(beats_seen) + 32'd1) * 32'd64 == 32'(wr_bytes));

  assert_burst_addr_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_ready && !wr_last |=> wr_valid && $stable(wr_addr) && $stable(wr_bytes));

  assert_hold_under_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_bytes) &&
                              $stable(wr_data) && $stable(wr_last));

  assert_no_accept_during_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !in_ready);

  assert_pad_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_data[511:208] == '0) && (wr_data[63:40] == '0) && (wr_data[143:128] == '0));

  assert_inside_ring_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> end_slot <= ADDR_W'(cfg_ring_entries));
endmodule

bind rx_cpl_coalescer rx_cpl_coalescer_chk #(.ADDR_W(ADDR_W), .PTR_W(PTR_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_mps(cfg_mps), .cfg_ring_base(cfg_ring_base),
  .cfg_ring_entries(cfg_ring_entries), .in_ready(in_ready), .wr_valid(wr_valid),
  .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_bytes(wr_bytes), .wr_data(wr_data),
  .wr_last(wr_last));

// File: tb/sim_rx_cpl_coalescer.sv
`timescale 1ns/1ps
module sim_rx_cpl_coalescer;
  localparam logic [31:0] BASE = 32'h8000_1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] cfg_mps = 2'd0;
  logic [31:0] cfg_ring_base = BASE;
  logic [15:0] cfg_ring_entries = 16'd64;
  logic [15:0] cfg_idle_limit = 16'd0;
  logic flush = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [15:0] in_flags = '0, in_buf_id = '0, in_gso_hdr_len = '0, in_gso_size = '0;
  logic [15:0] in_csum_start = '0, in_csum_off = '0;
  logic [7:0]  in_gso_type = '0;
  logic [63:0] in_tstamp = '0;
  logic wr_ready = 1'b0;
  logic wr_valid, wr_last;
  logic [31:0] wr_addr;
  logic [9:0]  wr_bytes;
  logic [511:0] wr_data;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  rx_cpl_coalescer u0 (
    .clk(clk), .rst_n(rst_n), .cfg_mps(cfg_mps), .cfg_ring_base(cfg_ring_base),
    .cfg_ring_entries(cfg_ring_entries), .cfg_idle_limit(cfg_idle_limit), .flush(flush),
    .in_valid(in_valid), .in_ready(in_ready), .in_flags(in_flags), .in_buf_id(in_buf_id),
    .in_gso_type(in_gso_type), .in_gso_hdr_len(in_gso_hdr_len), .in_gso_size(in_gso_size),
    .in_csum_start(in_csum_start), .in_csum_off(in_csum_off), .in_tstamp(in_tstamp),
    .wr_ready(wr_ready), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_bytes(wr_bytes),
    .wr_data(wr_data), .wr_last(wr_last));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [511:0] act, input logic [511:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] s_flags(int s); return 16'hA000 + 16'(s); endfunction
  function automatic logic [15:0] s_id(int s);    return 16'h1000 + 16'(s * 3); endfunction
  function automatic logic [7:0]  s_type(int s);  return 8'h40 + 8'(s); endfunction
  function automatic logic [15:0] s_hdr(int s);   return 16'h0100 + 16'(s); endfunction
  function automatic logic [15:0] s_gsz(int s);   return 16'h05DC - 16'(s); endfunction
  function automatic logic [15:0] s_cs(int s);    return 16'h0022 + 16'(s); endfunction
  function automatic logic [15:0] s_co(int s);    return 16'h0010 + 16'(s); endfunction
  function automatic logic [63:0] s_ts(int s);
    return {32'hCAFE_0000 + 32'(s), 32'h1234_5678 ^ 32'(s)};
  endfunction

  function automatic logic [511:0] exp_line(int s);
    logic [7:0] b [64];
    logic [511:0] r;
    for (int i = 0; i < 64; i++) b[i] = 8'h00;
    b[0] = s_flags(s)[7:0]; b[1] = s_flags(s)[15:8];
    b[2] = s_id(s)[7:0];    b[3] = s_id(s)[15:8];
    b[4] = s_type(s);
    b[8] = s_hdr(s)[7:0];   b[9] = s_hdr(s)[15:8];
    b[10] = s_gsz(s)[7:0];  b[11] = s_gsz(s)[15:8];
    b[12] = s_cs(s)[7:0];   b[13] = s_cs(s)[15:8];
    b[14] = s_co(s)[7:0];   b[15] = s_co(s)[15:8];
    for (int i = 0; i < 8; i++) b[18 + i] = s_ts(s)[i*8 +: 8];
    for (int i = 0; i < 64; i++) r[i*8 +: 8] = b[i];
    return r;
  endfunction

  task automatic do_reset(input logic [1:0] mps, input logic [15:0] entries, input logic [15:0] idle);
    @(negedge clk);
    rst_n = 1'b0; wr_ready = 1'b0; in_valid = 1'b0; flush = 1'b0;
    cfg_mps = mps; cfg_ring_entries = entries; cfg_idle_limit = idle;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic push(input int s);
    int w = 0;
    @(negedge clk);
    in_valid = 1'b1;
    in_flags = s_flags(s); in_buf_id = s_id(s); in_gso_type = s_type(s);
    in_gso_hdr_len = s_hdr(s); in_gso_size = s_gsz(s); in_csum_start = s_cs(s);
    in_csum_off = s_co(s); in_tstamp = s_ts(s);
    #1;
    while (!in_ready && w < 200) begin @(negedge clk); #1; w++; end
    chk(in_ready, "R8", "input never accepted", 512'(in_ready), 512'(1));
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic expect_write(input int n, input int idx, input int s0, input bit stall, input string req);
    int w = 0;
    @(negedge clk);
    while (!wr_valid && w < 100) begin @(negedge clk); w++; end
    chk(wr_valid, req, "write never started", 512'(wr_valid), 512'(1));
    if (!wr_valid) return;
    chk(wr_addr == BASE + 32'(idx * 64), "R7", "write address", 512'(wr_addr), 512'(BASE + 32'(idx * 64)));
    chk(wr_bytes == 10'(n * 64), "R3 R4", "write byte count", 512'(wr_bytes), 512'(n * 64));
    chk(!in_ready, "R8", "in_ready during write", 512'(in_ready), 512'(0));
    for (int b = 0; b < n; b++) begin
      if (stall) begin
        logic [511:0] held;
        held = wr_data;
        wr_ready = 1'b0;
        repeat (2) @(negedge clk);
        chk(wr_valid && wr_data == held, "R8", "beat changed under stall", wr_data, held);
      end
      wr_ready = 1'b1;
      chk(wr_valid, "R3", "beat missing", 512'(wr_valid), 512'(1));
      chk(wr_data == exp_line(s0 + b), "R1 R2", $sformatf("record beat %0d", b), wr_data, exp_line(s0 + b));
      chk(wr_last == (b == n - 1), "R3", $sformatf("last flag beat %0d", b), 512'(wr_last), 512'(b == n - 1));
      chk(wr_addr == BASE + 32'(idx * 64), "R3", "address moved in burst", 512'(wr_addr), 512'(BASE + 32'(idx * 64)));
      @(negedge clk);
    end
    wr_ready = 1'b0;
    chk(!wr_valid, "R3", "extra beat after last", 512'(wr_valid), 512'(0));
  endtask

  task automatic expect_quiet(input int cycles, input string req, input string what);
    bit seen = 1'b0;
    for (int i = 0; i < cycles; i++) begin @(negedge clk); if (wr_valid) seen = 1'b1; end
    chk(!seen, req, what, 512'(seen), 512'(0));
  endtask

  task automatic t_reset();
    do_reset(2'd0, 16'd64, 16'd0);
    @(negedge clk);
    chk(!wr_valid, "R9", "wr_valid after reset", 512'(wr_valid), 512'(0));
    chk(in_ready, "R9", "in_ready after reset", 512'(in_ready), 512'(1));
  endtask

  task automatic t_full_batches();
    for (int m = 0; m < 4; m++) begin
      int lim;
      lim = (m == 0) ? 2 : (m == 1) ? 4 : 8;
      do_reset(2'(m), 16'd64, 16'd0);
      for (int i = 0; i < lim - 1; i++) push(10 * m + i);
      expect_quiet(30, "R4", "partial batch written early");
      push(10 * m + lim - 1);
      expect_write(lim, 0, 10 * m, 1'b0, "R4");
      for (int i = 0; i < lim; i++) push(50 + i);
      expect_write(lim, lim, 50, 1'b0, "R7");
    end
  endtask

  task automatic t_backpressure();
    do_reset(2'd1, 16'd64, 16'd0);
    for (int i = 0; i < 4; i++) push(70 + i);
    expect_write(4, 0, 70, 1'b1, "R8");
  endtask

  task automatic t_flush();
    do_reset(2'd2, 16'd64, 16'd0);
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    expect_quiet(20, "R5", "write from flush with nothing held");
    for (int i = 0; i < 3; i++) push(90 + i);
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    expect_write(3, 0, 90, 1'b0, "R5");
  endtask

  task automatic t_idle();
    do_reset(2'd2, 16'd64, 16'd6);
    push(110);
    repeat (6) @(posedge clk);
    @(negedge clk);
    chk(!wr_valid, "R6", "timeout fired early", 512'(wr_valid), 512'(0));
    @(negedge clk);
    chk(wr_valid, "R6", "timeout did not fire", 512'(wr_valid), 512'(1));
    expect_write(1, 0, 110, 1'b0, "R6");
    do_reset(2'd2, 16'd64, 16'd0);
    push(120);
    expect_quiet(60, "R6", "timeout fired while disabled");
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    expect_write(1, 0, 120, 1'b0, "R6");
  endtask

  task automatic t_wrap();
    do_reset(2'd1, 16'd5, 16'd0);
    for (int i = 0; i < 4; i++) push(130 + i);
    expect_write(4, 0, 130, 1'b0, "R7");
    push(134);
    expect_write(1, 4, 134, 1'b0, "R7");
    push(135);
    push(136);
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    expect_write(2, 0, 135, 1'b0, "R7");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_full_batches();
    t_backpressure();
    t_flush();
    t_idle();
    t_wrap();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule